// File: doc/BRIEF.md
# DRAM Row Locator

This block maps a physical address onto one of the chip-select rows of a DRAM array. It keeps one small boundary register per row, loaded over a write-only configuration port. Each register holds the cumulative upper limit of its row in 8 MB units. A row begins where the row below it ends, and row 0 begins at address zero. A row whose limit repeats the limit below it holds no memory. A zero limit that follows a nonzero limit stands for the 2 GB top of the space.

On every cycle that `addr_valid` is high, the presented address is decoded against all rows in parallel. One clock later the result appears on the output register: a binary row number, a one-hot chip-select vector and a miss flag. This suits a pipelined access path where the row choice is needed one stage after the address.

The row count, limit width, unit size and address width are parameters. With the defaults there are eight rows of 8-bit limits and 32-bit addresses. A parameter can also remove the output register for use on a path that needs no pipelining.

Top module: `dram_row_locator`

## Requirements
- R1: Writing `cfg_wdata` to row `cfg_sel` while `cfg_we` is high replaces that row's limit at the clock edge. A lookup presented in the same cycle still uses the old limit; a lookup in the next cycle uses the new one.
- R2: Row i covers the addresses from the upper limit of row i-1 (zero for row 0) up to, but not including, its own limit. The limit in bytes is the register value shifted left by 23.
- R3: A row whose limit equals the limit of the row below it is empty and is never selected.
- R4: A limit of zero following a nonzero limit means address 0x8000_0000, so the row reaches the 2 GB top.
- R5: An address that falls in no row gives `out_of_range` = 1, `row_cs` all zero and `row_idx` = 0. This includes every address at or above the highest nonempty limit.
- R6: When misprogrammed limits let several rows contain an address, the lowest-numbered of them is selected.
- R7: Reset clears every limit to zero, so after reset every lookup misses.
- R8: In the default registered mode, `row_valid` is high exactly in the cycle after a cycle with `addr_valid` high. When `row_valid` is low, `row_cs`, `row_idx` and `out_of_range` are all zero.
- R9: On a hit, `row_idx` is the binary row number and `row_cs` has exactly that bit set (bit i for row i), with no other bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a boundary register |
| cfg_sel | input | 3 | Row whose boundary is written |
| cfg_wdata | input | 8 | New cumulative limit, in 8 MB units |
| addr_valid | input | 1 | Address on `addr` is to be decoded |
| addr | input | 32 | Physical byte address |
| row_valid | output | 1 | Decode result is present |
| row_idx | output | 3 | Binary number of the selected row |
| row_cs | output | 8 | One-hot chip-select, bit i for row i |
| out_of_range | output | 1 | Address lies in no populated row |

## Verification
A boundary write counts from the edge that stores it, so a lookup driven in the cycle after the write sees the new limit. A lookup driven in the write cycle still sees the old limit, and the bench checks both sides of that edge. Each lookup's result is due on the output register one edge after the lookup is driven. The bench drives inputs at the falling edge and queues the expected result with the lookup. It pops and compares the result shortly after the next rising edge. Every rising edge with an empty queue must show `row_valid` low and quiet outputs.

// File: rtl/drl_pkg.sv
package drl_pkg;

   // Output stage variant chosen by the top-level parameter.
   typedef enum logic {
      DRL_OUT_COMB = 1'b0,
      DRL_OUT_REG  = 1'b1
   } drl_out_e;

endpackage

// File: rtl/drl_limit_chain.sv
// Turns the raw boundary registers into effective byte limits and bases.
module drl_limit_chain #(
   parameter int NUM_ROWS   = 8,
   parameter int LIMIT_W    = 8,
   parameter int UNIT_SHIFT = 23,
   parameter int ADDR_W     = 32
) (
   input  logic [NUM_ROWS-1:0][LIMIT_W-1:0] bound_i,
   output logic [NUM_ROWS-1:0][ADDR_W-1:0]  base_o,
   output logic [NUM_ROWS-1:0][ADDR_W-1:0]  top_o,
   output logic [NUM_ROWS-1:0]              used_o
);

   // A zero after a nonzero limit stands for one unit past the widest limit.
   localparam logic [ADDR_W-1:0] WRAP_TOP = ADDR_W'(1) << (UNIT_SHIFT + LIMIT_W);

   always_comb begin
      logic [ADDR_W-1:0] below;
      logic [ADDR_W-1:0] raw;
      below = '0;
      for (int r = 0; r < NUM_ROWS; r++) begin
         raw       = ADDR_W'(bound_i[r]) << UNIT_SHIFT;
         base_o[r] = below;
         if (raw == '0 && below != '0) begin
            top_o[r] = WRAP_TOP;
         end else begin
            top_o[r] = raw;
         end
         used_o[r] = (top_o[r] != below);
         below     = top_o[r];
      end
   end

endmodule

// File: rtl/drl_row_match.sv
// Parallel range comparison of one address against every row.
module drl_row_match #(
   parameter int NUM_ROWS = 8,
   parameter int ADDR_W   = 32
) (
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [NUM_ROWS-1:0][ADDR_W-1:0]  base_i,
   input  logic [NUM_ROWS-1:0][ADDR_W-1:0]  top_i,
   input  logic [NUM_ROWS-1:0]              used_i,
   output logic [NUM_ROWS-1:0]              hit_o
);

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic above_base;
      logic below_top;
      assign above_base = (addr_i >= base_i[r]);
      assign below_top  = (addr_i <  top_i[r]);
      assign hit_o[r]   = used_i[r] & above_base & below_top;
   end

endmodule

// File: rtl/drl_prio_pick.sv
// Lowest-numbered request wins; reports one-hot grant, index and none.
module drl_prio_pick #(
   parameter int NUM_ROWS = 8,
   localparam int IDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic [NUM_ROWS-1:0] req_i,
   output logic [NUM_ROWS-1:0] gnt_o,
   output logic [IDX_W-1:0]    idx_o,
   output logic                none_o
);

   assign gnt_o  = req_i & (~req_i + NUM_ROWS'(1));
   assign none_o = ~|req_i;

   always_comb begin
      idx_o = '0;
      for (int r = NUM_ROWS - 1; r >= 0; r--) begin
         if (req_i[r]) begin
            idx_o = IDX_W'(r);
         end
      end
   end

endmodule

// File: rtl/dram_row_locator.sv
module dram_row_locator #(
   parameter int               NUM_ROWS   = 8,
   parameter int               LIMIT_W    = 8,
   parameter int               UNIT_SHIFT = 23,
   parameter int               ADDR_W     = 32,
   parameter drl_pkg::drl_out_e OUT_MODE  = drl_pkg::DRL_OUT_REG,
   localparam int              IDX_W      = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
   localparam int              SPAN_W     = UNIT_SHIFT + LIMIT_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_sel,
   input  logic [LIMIT_W-1:0]  cfg_wdata,
   input  logic                addr_valid,
   input  logic [ADDR_W-1:0]   addr,
   output logic                row_valid,
   output logic [IDX_W-1:0]    row_idx,
   output logic [NUM_ROWS-1:0] row_cs,
   output logic                out_of_range
);

   // Elaboration-time parameter checks.
   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("dram_row_locator: NUM_ROWS must be at least 2");
   end
   if (LIMIT_W < 1) begin : g_bad_limit
      $error("dram_row_locator: LIMIT_W must be at least 1");
   end
   if (ADDR_W < SPAN_W) begin : g_bad_addr
      $error("dram_row_locator: ADDR_W too narrow for the top-of-space limit");
   end

   // Boundary register file, one register per row.
   logic [NUM_ROWS-1:0][LIMIT_W-1:0] bound_q;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_bound
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bound_q[r] <= '0;
         end else if (cfg_we && cfg_sel == IDX_W'(r)) begin
            bound_q[r] <= cfg_wdata;
         end
      end
   end

   // Decode path.
   logic [NUM_ROWS-1:0][ADDR_W-1:0] row_base;
   logic [NUM_ROWS-1:0][ADDR_W-1:0] row_top;
   logic [NUM_ROWS-1:0]             row_used;
   logic [NUM_ROWS-1:0]             row_hit;
   logic [NUM_ROWS-1:0]             pick_gnt;
   logic [IDX_W-1:0]                pick_idx;
   logic                            pick_none;

   drl_limit_chain #(
      .NUM_ROWS   (NUM_ROWS),
      .LIMIT_W    (LIMIT_W),
      .UNIT_SHIFT (UNIT_SHIFT),
      .ADDR_W     (ADDR_W)
   ) u_chain (
      .bound_i (bound_q),
      .base_o  (row_base),
      .top_o   (row_top),
      .used_o  (row_used)
   );

   drl_row_match #(
      .NUM_ROWS (NUM_ROWS),
      .ADDR_W   (ADDR_W)
   ) u_match (
      .addr_i (addr),
      .base_i (row_base),
      .top_i  (row_top),
      .used_i (row_used),
      .hit_o  (row_hit)
   );

   drl_prio_pick #(
      .NUM_ROWS (NUM_ROWS)
   ) u_pick (
      .req_i  (row_hit),
      .gnt_o  (pick_gnt),
      .idx_o  (pick_idx),
      .none_o (pick_none)
   );

   // Output stage: registered for pipelined paths, or pass-through.
   if (OUT_MODE == drl_pkg::DRL_OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            row_valid    <= 1'b0;
            row_idx      <= '0;
            row_cs       <= '0;
            out_of_range <= 1'b0;
         end else if (addr_valid) begin
            row_valid    <= 1'b1;
            row_idx      <= pick_idx;
            row_cs       <= pick_gnt;
            out_of_range <= pick_none;
         end else begin
            row_valid    <= 1'b0;
            row_idx      <= '0;
            row_cs       <= '0;
            out_of_range <= 1'b0;
         end
      end
   end else begin : g_out_comb
      assign row_valid    = addr_valid;
      assign row_idx      = addr_valid ? pick_idx : '0;
      assign row_cs       = addr_valid ? pick_gnt : '0;
      assign out_of_range = addr_valid & pick_none;
   end

endmodule

// File: rtl/drl_checker.sv
module drl_checker #(
   parameter int NUM_ROWS = 8,
   parameter int IDX_W    = 3,
   parameter bit OUT_REG  = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                addr_valid,
   input logic                row_valid,
   input logic [IDX_W-1:0]    row_idx,
   input logic [NUM_ROWS-1:0] row_cs,
   input logic                out_of_range
);

   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid |-> $onehot0(row_cs)); // R9

   AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && !out_of_range) |-> (row_cs == (NUM_ROWS'(1) << row_idx))); // R9

   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && out_of_range) |-> (row_cs == '0 && row_idx == '0)); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !row_valid |-> (row_cs == '0 && row_idx == '0 && !out_of_range)); // R8

   if (OUT_REG) begin : g_lat
      AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         addr_valid |=> row_valid); // R8

      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         !addr_valid |=> !row_valid); // R8
   end

endmodule

bind dram_row_locator drl_checker #(
   .NUM_ROWS (NUM_ROWS),
   .IDX_W    (IDX_W),
   .OUT_REG  (OUT_MODE == drl_pkg::DRL_OUT_REG)
) u_drl_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .addr_valid   (addr_valid),
   .row_valid    (row_valid),
   .row_idx      (row_idx),
   .row_cs       (row_cs),
   .out_of_range (out_of_range)
);

// File: tb/test_dram_row_locator.sv
`timescale 1ns/1ps
module test_dram_row_locator;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        addr_valid = 1'b0;
   logic [31:0] addr = '0;
   logic        row_valid;
   logic [2:0]  row_idx;
   logic [7:0]  row_cs;
   logic        out_of_range;

   always #10 clk = ~clk;   // 50 MHz

   dram_row_locator i_dram_row_locator (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .addr_valid   (addr_valid),
      .addr         (addr),
      .row_valid    (row_valid),
      .row_idx      (row_idx),
      .row_cs       (row_cs),
      .out_of_range (out_of_range)
   );

   typedef struct {
      logic [2:0] idx;
      logic [7:0] cs;
      logic       oor;
      string      req;
   } exp_t;

   exp_t       sb_q[$];
   logic [7:0] m_bound [8];
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Reference from the requirements: cumulative limits, empty rows skipped,
   // zero after nonzero is the 2 GB top, lowest row wins.
   function automatic void model(input logic [31:0] a, output logic [2:0] idx,
                                 output logic [7:0] cs, output logic oor);
      logic [32:0] prev;
      logic [32:0] top;
      prev = '0;
      oor  = 1'b1;
      cs   = '0;
      idx  = '0;
      for (int i = 0; i < 8; i++) begin
         top = 33'(m_bound[i]) << 23;
         if (top == 0 && prev != 0) top = 33'h0_8000_0000;
         if (oor && top != prev && {1'b0, a} >= prev && {1'b0, a} < top) begin
            oor = 1'b0;
            idx = 3'(i);
            cs  = 8'(1) << i;
         end
         prev = top;
      end
   endfunction

   // Driver: one cycle of stimulus, set at the falling edge.
   task automatic drive(input bit we, input int sel, input int data,
                        input bit av, input logic [31:0] a,
                        input bit use_model, input int x_idx, input bit x_oor,
                        input string req);
      exp_t e;
      @(negedge clk);
      cfg_we     = we;
      cfg_sel    = 3'(sel);
      cfg_wdata  = 8'(data);
      addr_valid = av;
      addr       = a;
      if (av) begin
         if (use_model) begin
            model(a, e.idx, e.cs, e.oor);
         end else begin
            e.oor = x_oor;
            e.idx = x_oor ? 3'd0 : 3'(x_idx);
            e.cs  = x_oor ? 8'd0 : (8'(1) << x_idx);
         end
         e.req = req;
         sb_q.push_back(e);
      end
      if (we) m_bound[sel] = 8'(data);
   endtask

   task automatic wr(input int sel, input int data);
      drive(1'b1, sel, data, 1'b0, '0, 1'b1, 0, 1'b0, "R1");
   endtask

   task automatic look(input logic [31:0] a, input int idx, input bit oor, input string req);
      drive(1'b0, 0, 0, 1'b1, a, 1'b0, idx, oor, req);
   endtask

   task automatic look_m(input logic [31:0] a, input string req);
      drive(1'b0, 0, 0, 1'b1, a, 1'b1, 0, 1'b0, req);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) drive(1'b0, 0, 0, 1'b0, '0, 1'b1, 0, 1'b0, "R8");
   endtask

   task automatic load(input int b0, input int b1, input int b2, input int b3,
                       input int b4, input int b5, input int b6, input int b7);
      wr(0, b0); wr(1, b1); wr(2, b2); wr(3, b3);
      wr(4, b4); wr(5, b5); wr(6, b6); wr(7, b7);
   endtask

   // Monitor: each result is due one rising edge after its lookup.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (sb_q.size() > 0) begin
               exp_t e;
               e = sb_q.pop_front();
               check(row_valid === 1'b1, "R8", "row_valid", row_valid, 1);
               check(out_of_range === e.oor, e.req, "out_of_range", out_of_range, e.oor);
               check(row_idx === e.idx, e.req, "row_idx", row_idx, e.idx);
               check(row_cs === e.cs, (e.req == "R9") ? "R9" : e.req, "row_cs", row_cs, e.cs);
            end else begin
               check(row_valid === 1'b0 && row_cs === 8'd0 && out_of_range === 1'b0,
                     "R8", "idle outputs", {row_valid, out_of_range, row_cs}, 0);
            end
         end
      end
   end

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // Watchdog
   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R8 watchdog: actual=timeout expected=finish");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_bound[i] = '0;
      repeat (3) @(negedge clk);
      // R7: reset state of the outputs
      check(row_valid === 1'b0 && row_cs === 8'd0 && out_of_range === 1'b0 && row_idx === 3'd0,
            "R7", "outputs in reset", {row_valid, out_of_range, row_cs}, 0);
      rst_n = 1'b1;
      idle(2);

      // R7: nothing installed after reset
      look(32'h0000_0000, 0, 1'b1, "R7");
      look(32'h7FFF_FFFF, 0, 1'b1, "R7");
      idle(1);

      // Layout A: row0 [0,32M) row1 empty row2 [32M,64M) row3 [64M,128M)
      // row4 empty row5 [128M,256M) rows 6,7 empty
      load(4, 4, 8, 16, 16, 32, 32, 32);
      look(32'h0000_0000, 0, 1'b0, "R2");
      look(32'h01FF_FFFF, 0, 1'b0, "R2");
      look(32'h0200_0000, 2, 1'b0, "R3");
      look(32'h0400_0000, 3, 1'b0, "R9");
      look(32'h0800_0000, 5, 1'b0, "R3");
      look(32'h0FFF_FFFF, 5, 1'b0, "R2");
      look(32'h1000_0000, 0, 1'b1, "R5");
      look(32'hFFFF_FFFF, 0, 1'b1, "R5");
      idle(2);
      for (int s = 0; s < 40; s++) look_m(32'(s) * 32'h0080_0000 + 32'h0000_1000, "R2");
      idle(1);

      // R1: write and lookup in the same cycle use the old limit
      drive(1'b1, 0, 2, 1'b1, 32'h0180_0000, 1'b0, 0, 1'b0, "R1");
      look(32'h0180_0000, 1, 1'b0, "R1");
      look(32'h0080_0000, 0, 1'b0, "R1");
      idle(1);

      // Layout B: row0 [0,1G), row1 up to the 2 GB top, rest empty
      load(8'h80, 0, 0, 0, 0, 0, 0, 0);
      look(32'h3FFF_FFFF, 0, 1'b0, "R2");
      look(32'h4000_0000, 1, 1'b0, "R4");
      look(32'h7FFF_FFFF, 1, 1'b0, "R4");
      look(32'h8000_0000, 0, 1'b1, "R5");
      idle(1);

      // Overlap: row0 [0,64M), row1 inverted, row2 [32M,96M)
      load(8, 4, 12, 12, 12, 12, 12, 12);
      look(32'h0280_0000, 0, 1'b0, "R6");
      look(32'h0450_0000, 2, 1'b0, "R6");
      look(32'h0600_0000, 0, 1'b1, "R5");
      idle(1);
      for (int s = 0; s < 14; s++) look_m(32'(s) * 32'h0080_0000, "R6");
      idle(3);

      check(sb_q.size() == 0, "R8", "pending results", sb_q.size(), 0);
      done = 1'b1;
      finish_run();
   end

endmodule